// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block models the read side of a two-wire serial EEPROM holding 256 bytes. A host drives the clock and data wire levels as a stream of discrete updates: each update is one system-clock cycle with the strobe high, carrying the new clock level and the new data level. The block compares each update with the levels it stored from the previous update. From that comparison it finds bus start and stop conditions and rising clock edges. It then collects a control byte and a word address, and answers with acknowledge bits. After the address byte it loads the addressed byte from a constant image.

The byte that was loaded is shifted out most significant bit first. This happens on the accepted address bits of the next read transaction. After each address byte the responder goes back to idle, and only a new start condition wakes it again. Writing data into the memory is not modelled. The data level the slave presents is the last stored data level, after the slave's own overrides have been applied.

Top module: `i2c_rom_slave`

## Requirements
- R1: A start condition (clock high in both the stored and the new level, data falling from 1 to 0) sets the bit counter to 1 and clears the control byte, and the presented data becomes 0. A stop condition (clock high in both, data rising) changes nothing except the stored levels.
- R2: While the bit counter is 0 and no acknowledge is pending, every update other than a start is ignored, and the presented data simply follows the written data level.
- R3: A bit is accepted only on a rising clock (stored 0, new 1) whose data level equals the stored data level. A rising edge that changes the data level as well is discarded and does not advance the counter.
- R4: When an acknowledge is pending, the next rising clock edge presents data 0 and clears the pending flag, whatever level the host writes.
- R5: The first eight accepted bits after a start form the control byte, MSB first, and during them the presented data follows the host. After the eighth bit an acknowledge is pending. Control bit 0 selects read (1) or write (0). With write selected, the address bits present the host level unchanged.
- R6: The next eight accepted bits form the word address, MSB first. With read selected, each of these edges presents the top bit of the data register, and the data register then shifts left by one.
- R7: On the eighth address bit the data register is loaded from the image at the completed address, an acknowledge becomes pending, and the counter returns to 0. Once that acknowledge has been given, further clock pulses are ignored until a start.
- R8: After reset the presented data is 1, and the stored levels are 1, which is an idle bus. The counter, the pending flag, the control byte, the address and the data register are all 0.
- R9: Cycles without the update strobe change neither the presented data nor any state.
- R10: The default image holds 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40, 0x00 at addresses 0 to 7 and 0x00 everywhere else.
- R11: The presented data always equals the data level written by the latest update, except where R4, R5 or R6 override it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_i | input | 1 | Update strobe: one pin update per cycle while high |
| scl_i | input | 1 | New clock wire level for this update |
| sda_i | input | 1 | New data wire level for this update |
| sda_o | output | 1 | Data level presented by the slave |

## Verification
The assertions assume that the input levels carry meaning only in cycles where the strobe is high. They also assume that each strobed cycle is exactly one wire update, so a start, a stop and a rising edge are always judged against the levels stored at the previous strobe. The stimulus follows these rules. Every level change goes through one strobed cycle, driven on the falling clock edge. Strobe-free cycles are mixed in, and random level pairs are also applied, so that stops in the middle of a transaction, glitching edges and repeated starts reach every counter position.

// File: rtl/i2c_rom_pkg.sv
package i2c_rom_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int IMG_W  = DEPTH * BYTE_W;
  localparam int TICK_W = 5;

  // counter positions: control byte ends at 9, address byte ends at 17
  localparam logic [TICK_W-1:0] T_FIRST   = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CMD_END = TICK_W'(BYTE_W + 1);
  localparam logic [TICK_W-1:0] T_ADR_END = TICK_W'(2 * BYTE_W + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic logic [IMG_W-1:0] default_image();
    logic [IMG_W-1:0] img;
    img = '0;
    img[0*BYTE_W +: BYTE_W] = 8'h80;
    img[1*BYTE_W +: BYTE_W] = 8'h08;
    img[2*BYTE_W +: BYTE_W] = 8'h04;
    img[3*BYTE_W +: BYTE_W] = 8'h0D;
    img[4*BYTE_W +: BYTE_W] = 8'h0A;
    img[5*BYTE_W +: BYTE_W] = 8'h01;
    img[6*BYTE_W +: BYTE_W] = 8'h40;
    img[7*BYTE_W +: BYTE_W] = 8'h00;
    return img;
  endfunction

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic scl_q_i,
  input  logic sda_q_i,
  input  logic scl_n_i,
  input  logic sda_n_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic steady_o
);

  logic held_high;

  // clock high across the update while data moves: bus condition
  assign held_high = scl_q_i & scl_n_i & (sda_q_i ^ sda_n_i);
  assign start_o   = held_high & ~sda_n_i;
  assign stop_o    = held_high &  sda_n_i;
  assign rise_o    = ~scl_q_i & scl_n_i;
  assign steady_o  = (sda_q_i == sda_n_i);

endmodule

// File: rtl/i2c_rom_image.sv
module i2c_rom_image
  import i2c_rom_pkg::*;
#(
  parameter logic [IMG_W-1:0] IMAGE = default_image()
) (
  input  addr_t addr_i,
  output byte_t byte_o
);

  assign byte_o = IMAGE[addr_i*BYTE_W +: BYTE_W];

endmodule

// File: rtl/i2c_rom_seq.sv
module i2c_rom_seq
  import i2c_rom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_i,
  input  logic  sda_i,
  input  logic  scl_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  logic  rise_i,
  input  logic  steady_i,
  input  byte_t rom_byte_i,
  output addr_t rom_addr_o,
  output logic  scl_q_o,
  output logic  sda_q_o
);

  logic              scl_q, scl_d;
  logic              sda_q, sda_d;
  logic              ack_q, ack_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  byte_t             cmd_q, cmd_d;
  addr_t             addr_q, addr_d;
  byte_t             data_q, data_d;
  addr_t             addr_shift;

  assign addr_shift = {addr_q[ADDR_W-2:0], sda_i};
  assign rom_addr_o = addr_shift;

  always_comb begin
    scl_d  = scl_i;
    sda_d  = sda_i;
    ack_d  = ack_q;
    tick_d = tick_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    if (start_i) begin
      tick_d = T_FIRST;
      cmd_d  = '0;
    end else if (stop_i) begin
      // stop: only the stored levels move
    end else if (tick_q == '0 && !ack_q) begin
      // idle: wait for a start
    end else if (rise_i) begin
      if (ack_q) begin
        sda_d = 1'b0;
        ack_d = 1'b0;
      end else if (steady_i) begin
        if (tick_q < T_CMD_END) begin
          cmd_d  = {cmd_q[BYTE_W-2:0], sda_i};
          tick_d = tick_q + 1'b1;
          if (tick_q == T_CMD_END - 1'b1) ack_d = 1'b1;
        end else if (tick_q < T_ADR_END) begin
          if (cmd_q[0]) sda_d = data_q[BYTE_W-1];
          addr_d = addr_shift;
          data_d = {data_q[BYTE_W-2:0], 1'b0};
          tick_d = tick_q + 1'b1;
          if (tick_q == T_ADR_END - 1'b1) begin
            data_d = rom_byte_i;
            ack_d  = 1'b1;
            tick_d = '0;
          end
        end else begin
          sda_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ack_q  <= 1'b0;
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (upd_i) begin
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      ack_q  <= ack_d;
      tick_q <= tick_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign scl_q_o = scl_q;
  assign sda_q_o = sda_q;

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && start_i |=> tick_q == T_FIRST && cmd_q == '0 && !sda_q); // R1
  AST_STOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && stop_i |=> $stable(tick_q) && $stable(ack_q) && $stable(cmd_q)); // R1
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && !start_i && tick_q == '0 && !ack_q |=> tick_q == '0 && !ack_q && sda_q == $past(sda_i)); // R2
  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && rise_i && !steady_i && !ack_q |=> $stable(tick_q) && $stable(cmd_q)); // R3
  AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && rise_i && ack_q |=> !sda_q && !ack_q); // R4
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && rise_i && steady_i && !ack_q && tick_q == T_CMD_END - 1'b1 |=> ack_q && tick_q == T_CMD_END); // R5
  AST_ADDR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && rise_i && steady_i && !ack_q && tick_q == T_ADR_END - 1'b1 |=> ack_q && tick_q == '0); // R7
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(sda_q) && $stable(tick_q) && $stable(data_q)); // R9

endmodule

// File: rtl/i2c_rom_slave.sv
module i2c_rom_slave
  import i2c_rom_pkg::*;
#(
  parameter logic [IMG_W-1:0] IMAGE = default_image()
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       scl_q, sda_q;
  logic       start, stop, rise, steady;
  addr_t      rom_addr;
  byte_t      rom_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_line_watch u_watch (
    .scl_q_i (scl_q),
    .sda_q_i (sda_q),
    .scl_n_i (scl_i),
    .sda_n_i (sda_i),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (rise),
    .steady_o(steady)
  );

  i2c_rom_image #(.IMAGE(IMAGE)) u_image (
    .addr_i(rom_addr),
    .byte_o(rom_byte)
  );

  i2c_rom_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd_i     (upd_i),
    .sda_i     (sda_i),
    .scl_i     (scl_i),
    .start_i   (start),
    .stop_i    (stop),
    .rise_i    (rise),
    .steady_i  (steady),
    .rom_byte_i(rom_byte),
    .rom_addr_o(rom_addr),
    .scl_q_o   (scl_q),
    .sda_q_o   (sda_q)
  );

  assign sda_o = sda_q;

endmodule

// File: tb/i2c_rom_slave_bench.sv
module i2c_rom_slave_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_i = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic sda_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_scl = 1, m_sda = 1, m_tick = 0, m_ack = 0;
  int m_cmd = 0, m_addr = 0, m_data = 0;

  always #10 clk = ~clk;

  i2c_rom_slave u_i2c_rom_slave (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
    .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o)
  );

  function automatic int img(int a);
    case (a)
      0: return 'h80; 1: return 'h08; 2: return 'h04; 3: return 'h0D;
      4: return 'h0A; 5: return 'h01; 6: return 'h40;
      default: return 0;
    endcase
  endfunction

  task automatic model(int c, int d);
    int nd = d;
    if (m_scl == 1 && c == 1 && m_sda != d) begin
      if (d == 0) begin m_tick = 1; m_cmd = 0; end
    end else if (m_tick == 0 && m_ack == 0) begin
    end else if (m_scl == 0 && c == 1) begin
      if (m_ack == 1) begin
        nd = 0; m_ack = 0;
      end else if (m_sda == d) begin
        if (m_tick < 9) begin
          m_cmd = ((m_cmd << 1) | d) & 255;
          m_tick++;
          if (m_tick == 9) m_ack = 1;
        end else if (m_tick < 17) begin
          if ((m_cmd & 1) == 1) nd = (m_data >> 7) & 1;
          m_addr = ((m_addr << 1) | d) & 255;
          m_data = (m_data << 1) & 255;
          m_tick++;
          if (m_tick == 17) begin
            m_data = img(m_addr); m_ack = 1; m_tick = 0;
          end
        end else nd = 0;
      end
    end
    m_scl = c;
    m_sda = nd;
  endtask

  // per-clock comparison against the reference (R11, R9)
  task automatic cmp_cycle();
    total++;
    if (sda_o !== m_sda[0]) begin
      bad++;
      $display("FAIL R11 cycle %0d: sda_o=%0b expected %0d", cyc, sda_o, m_sda);
    end
  endtask

  task automatic send(int c, int d);
    @(negedge clk);
    cmp_cycle();
    upd_i = 1'b1; scl_i = c[0]; sda_i = d[0];
    model(c, d);
  endtask

  task automatic look(int exp, string tag);
    @(negedge clk);
    cmp_cycle();
    total++;
    if (sda_o !== exp[0]) begin
      bad++;
      $display("FAIL %s: sda_o=%0b expected %0d", tag, sda_o, exp);
    end
    upd_i = 1'b0;
  endtask

  task automatic bit_chk(int d, int exp, string tag);
    send(0, d); send(1, d); look(exp, tag); send(0, d);
  endtask

  task automatic start_cond();
    send(0, 1); send(1, 1); send(1, 0);
    look(0, "R1 start presents 0");
    send(0, 0);
  endtask

  // eight bits MSB first, checking the presented level after each rise
  task automatic byte_chk(int b, int exp, string tag);
    for (int i = 7; i >= 0; i--) bit_chk((b >> i) & 1, (exp >> i) & 1, tag);
  endtask

  task automatic read_txn(int adr, int exp_out, string tag);
    start_cond();
    byte_chk('hA1, 'hA1, "R5 control byte follows host");
    bit_chk(1, 0, "R4 ack after control");
    byte_chk(adr, exp_out, tag);
    bit_chk(1, 0, "R7 ack after address");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL R11 watchdog expired: cycles=%0d expected below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) look(1, "R8 reset state");

    // idle behaviour
    send(0, 0); look(0, "R2 idle follows host");
    send(1, 0); look(0, "R2 idle rise ignored");
    send(1, 1); look(1, "R1 stop only moves level");
    bit_chk(1, 1, "R2 idle bit ignored");
    repeat (5) look(1, "R9 no strobe hold");

    // first read, with a glitching rise before the control byte
    start_cond();
    send(0, 0); send(1, 1); look(1, "R3 glitch rise discarded"); send(0, 1);
    byte_chk('hA1, 'hA1, "R3 R5 control byte after glitch");
    bit_chk(1, 0, "R4 ack after control");
    byte_chk('h03, 'h00, "R6 empty data register shifts zeros");
    bit_chk(1, 0, "R7 ack after address");
    bit_chk(1, 1, "R7 idle after address ack");

    read_txn('hFF, 'h0D, "R6 R10 byte at 3 shifted out");
    read_txn('h07, 'h00, "R10 byte at 0xFF is zero");
    read_txn('h00, 'h00, "R10 byte at 7 is zero");
    read_txn('h00, 'h80, "R10 byte at 0");

    // write direction passes the host level through
    start_cond();
    byte_chk('hA0, 'hA0, "R5 write control byte");
    bit_chk(1, 0, "R4 ack after write control");
    byte_chk('h5A, 'h5A, "R5 write address follows host");
    bit_chk(1, 0, "R7 ack after write address");

    // random pin traffic, compared every cycle against the reference
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 5) == 0) begin
        @(negedge clk); cmp_cycle(); upd_i = 1'b0;
      end else begin
        send(int'($urandom % 2), int'($urandom % 2));
      end
    end
    look(m_sda, "R11 after random traffic");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule